// File: doc/BRIEF.md
# Word-Wide Stored-Program ALU Core

This block is a small 8-bit processor. Its program sits in an instruction store that is written through a dedicated load port. A program counter steps through that store. Each instruction names an ALU operation, two source registers and a destination register in an eight-entry register file. The result is written back to the destination. One instruction tests a register bit and moves the program counter by a signed amount held in a register, which lets programs build loops and if-then structures. A halt instruction stops the core and raises a flag.

Instructions are 16 bits wide:

- bits [15:12] hold the opcode.
- bits [11:9] hold the destination register.
- bits [8:6] hold the first source register.
- bits [5:3] hold the second source register.
- bits [2:0] are reserved. They are not stored, so the load port carries only bits [15:3].

The controller is a three-state machine:

- `ST_FETCH` latches the addressed word and always moves to `ST_EXEC`.
- `ST_EXEC` performs the instruction and updates the program counter. It returns to `ST_FETCH`, or moves to `ST_HALTED` when the opcode is HALT.
- `ST_HALTED` holds until reset.

Programs are loaded while reset is held. Results are then read through a combinational observation port that selects any register.

Top module: `wproc_core`

## Requirements
- R1: While reset is asserted the program counter is 0, all registers read 0 and `halted` is low.
- R2: A word presented with `prog_we` high is stored at `prog_addr` on the clock edge, and this works while reset is asserted.
- R3: ADD (0000) and SUB (0010) write SRC1+SRC2 and SRC1-SRC2, modulo 256, to the destination. For example, 0x18+0x14=0x2C and 0x18-0x14=0x04.
- R4: INV (0001) writes the complement of SRC1. AND (0101), OR (0110) and XOR (0111) write the bitwise result of SRC1 and SRC2, for example 0x18 XOR 0x14 = 0x0C.
- R5: SLL (0011) writes SRC1 shifted left by one. SLR (0100) writes SRC1 shifted right by one with zero fill. For example, 0x18 shifted left is 0x30.
- R6: BRANCH (1000) writes no register. If bit 0 of SRC1 is 1, the next PC is PC + SRC2, with SRC2 read as a signed 8-bit value so that backward jumps work. Otherwise the next PC is PC+1, including when other bits of SRC1 are set.
- R7: The PC wraps modulo the instruction-store depth (32), both when stepping past the last word and when a branch target leaves the range.
- R8: HALT (1111) raises `halted`, freezes the PC and stops all register writes. Instructions placed after it never take effect.
- R9: Every instruction takes exactly two cycles, fetch then execute. `halted` is first high after the 2*N-th rising edge after reset release, where N is the number of instructions run including the HALT.
- R10: Opcodes 1001 to 1110 change no register and advance the PC by one.
- R11: `obs_data` shows the current content of the register chosen by `obs_sel`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 5 | Instruction store write address |
| prog_word | input | 13 | Instruction bits [15:3] to store |
| obs_sel | input | 3 | Register selected for observation |
| obs_data | output | 8 | Content of the selected register |
| halted | output | 1 | High once HALT has executed |

## Verification
The two functions that can land in the same cycle are a taken branch and the program-counter wrap. A branch whose signed offset carries the target below address 0 must land near the top of the store. Separately, a plain step from the last word must land on address 0.

One program provokes both cases:

- A branch with offset -8 sits at address 7.
- The word at address 31 arms a branch at address 0.
- The armed branch jumps to a HALT that is never reached on the first pass.

Correctness is judged from the final register contents and from the exact cycle at which `halted` rises. A wrong landing address changes either the values or the instruction count.

// File: rtl/wproc_pkg.sv
package wproc_pkg;

    localparam int OPC_W  = 4;
    localparam int REG_AW = 3;
    localparam int NREG   = 1 << REG_AW;
    localparam int RSV_W  = 3;
    localparam int INSTR_W = OPC_W + 3 * REG_AW + RSV_W;
    localparam int STORE_W = INSTR_W - RSV_W;

    // field positions inside the stored word (reserved bits dropped)
    localparam int OPC_LO = 3 * REG_AW;
    localparam int DST_LO = 2 * REG_AW;
    localparam int S1_LO  = REG_AW;
    localparam int S2_LO  = 0;

    localparam logic [OPC_W-1:0] OP_ADD  = 4'b0000;
    localparam logic [OPC_W-1:0] OP_INV  = 4'b0001;
    localparam logic [OPC_W-1:0] OP_SUB  = 4'b0010;
    localparam logic [OPC_W-1:0] OP_SLL  = 4'b0011;
    localparam logic [OPC_W-1:0] OP_SLR  = 4'b0100;
    localparam logic [OPC_W-1:0] OP_AND  = 4'b0101;
    localparam logic [OPC_W-1:0] OP_OR   = 4'b0110;
    localparam logic [OPC_W-1:0] OP_XOR  = 4'b0111;
    localparam logic [OPC_W-1:0] OP_BRC  = 4'b1000;
    localparam logic [OPC_W-1:0] OP_HALT = 4'b1111;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_EXEC   = 2'd1,
        ST_HALTED = 2'd2
    } state_e;

endpackage

// File: rtl/wproc_imem.sv
module wproc_imem #(
    parameter int DEPTH = 32,
    parameter int W     = 13,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/wproc_regfile.sv
module wproc_regfile
    import wproc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [REG_AW-1:0] ra,
    output logic [DW-1:0]     rda,
    input  logic [REG_AW-1:0] rb,
    output logic [DW-1:0]     rdb,
    input  logic [REG_AW-1:0] ro,
    output logic [DW-1:0]     rdo
);

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rda = regs[ra];
    assign rdb = regs[rb];
    assign rdo = regs[ro];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(waddr)] == $past(wdata))); // R3

endmodule

// File: rtl/wproc_alu.sv
module wproc_alu
    import wproc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OPC_W-1:0] op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    output logic [DW-1:0]    y,
    output logic             writes
);

    always_comb begin
        y      = '0;
        writes = 1'b1;
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_INV:  y = ~a;
            OP_SLL:  y = {a[DW-2:0], 1'b0};
            OP_SLR:  y = {1'b0, a[DW-1:1]};
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: writes = 1'b0;
        endcase
    end

endmodule

// File: rtl/wproc_core.sv
module wproc_core
    import wproc_pkg::*;
#(
    parameter int DW         = 8,
    parameter int IMEM_DEPTH = 32,
    localparam int IA_W      = $clog2(IMEM_DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       prog_we,
    input  logic [IA_W-1:0]            prog_addr,
    input  logic [INSTR_W-1:RSV_W]     prog_word,
    input  logic [REG_AW-1:0]          obs_sel,
    output logic [DW-1:0]              obs_data,
    output logic                       halted
);

    state_e               state, state_nx;
    logic [IA_W-1:0]      pc, pc_nx, br_off;
    logic [STORE_W-1:0]   ir, imem_rd;
    logic [OPC_W-1:0]     opc;
    logic [REG_AW-1:0]    dst, s1, s2;
    logic [DW-1:0]        va, vb, alu_y;
    logic                 alu_wr, rf_we, br_take;

    assign opc = ir[OPC_LO +: OPC_W];
    assign dst = ir[DST_LO +: REG_AW];
    assign s1  = ir[S1_LO  +: REG_AW];
    assign s2  = ir[S2_LO  +: REG_AW];

    wproc_imem #(.DEPTH(IMEM_DEPTH), .W(STORE_W)) u_imem (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_word),
        .raddr (pc),
        .rdata (imem_rd)
    );

    wproc_regfile #(.DW(DW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (dst),
        .wdata (alu_y),
        .ra    (s1),
        .rda   (va),
        .rb    (s2),
        .rdb   (vb),
        .ro    (obs_sel),
        .rdo   (obs_data)
    );

    wproc_alu #(.DW(DW)) u_alu (
        .op     (opc),
        .a      (va),
        .b      (vb),
        .y      (alu_y),
        .writes (alu_wr)
    );

    // signed register offset brought to the PC width
    generate
        if (IA_W <= DW) begin : g_off_trunc
            assign br_off = vb[IA_W-1:0];
        end else begin : g_off_sext
            assign br_off = {{(IA_W-DW){vb[DW-1]}}, vb};
        end
    endgenerate

    assign rf_we   = (state == ST_EXEC) && alu_wr;
    assign br_take = (opc == OP_BRC) && va[0];

    always_comb begin
        if (opc == OP_HALT) begin
            pc_nx = pc;
        end else if (br_take) begin
            pc_nx = pc + br_off;
        end else begin
            pc_nx = pc + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:  state_nx = ST_EXEC;
            ST_EXEC:   state_nx = (opc == OP_HALT) ? ST_HALTED : ST_FETCH;
            ST_HALTED: state_nx = ST_HALTED;
            default:   state_nx = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            ir     <= '0;
            halted <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH:  ir <= imem_rd;
                ST_EXEC: begin
                    pc <= pc_nx;
                    if (opc == OP_HALT) begin
                        halted <= 1'b1;
                    end
                end
                ST_HALTED: halted <= 1'b1;
                default:   ;
            endcase
        end
    end

    AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_EXEC)); // R9

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R8

    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc)); // R8

    AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !rf_we); // R8

    AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && opc == OP_BRC) |-> !rf_we); // R6

    AST_PC_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && opc != OP_BRC && opc != OP_HALT)
        |=> (pc == IA_W'($past(pc) + 1'b1))); // R7

endmodule

// File: tb/wproc_core_bench.sv
module wproc_core_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [4:0]  prog_addr = '0;
    logic [12:0] prog_word = '0;
    logic [2:0]  obs_sel = '0;
    logic [7:0]  obs_data;
    logic        halted;

    int tests = 0;
    int fails = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int         idx;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q [$];

    logic [15:0] prog [DEPTH];
    logic [7:0]  mdl_r [8];

    always #5 clk = ~clk;

    wproc_core u_wproc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_word (prog_word),
        .obs_sel   (obs_sel),
        .obs_data  (obs_data),
        .halted    (halted)
    );

    function automatic logic [15:0] enc(logic [3:0] op, int d, int a, int b);
        return {op, 3'(d), 3'(a), 3'(b), 3'b000};
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
        end
    endtask

    // monitor: pops expected register contents and compares via the observation port
    always @(negedge clk) begin
        if (mon_en && exp_q.size() != 0) begin
            exp_t it;
            it = exp_q.pop_front();
            obs_sel = 3'(it.idx);
            #1;
            chk(obs_data === it.val, it.tag, $sformatf("r%0d", it.idx), obs_data, it.val);
        end
    end

    // reference model written from the requirements
    task automatic model_run(output int steps);
        int pc = 0;
        steps = 0;
        for (int i = 0; i < 8; i++) mdl_r[i] = 8'h00;
        for (int k = 0; k < 1000; k++) begin
            logic [15:0] w;
            logic [3:0]  op;
            logic [7:0]  a, b;
            int d;
            w  = prog[pc];
            op = w[15:12];
            d  = int'(w[11:9]);
            a  = mdl_r[w[8:6]];
            b  = mdl_r[w[5:3]];
            steps++;
            if (op == 4'b1111) break;
            case (op)
                4'b0000: mdl_r[d] = a + b;
                4'b0010: mdl_r[d] = a - b;
                4'b0001: mdl_r[d] = ~a;
                4'b0011: mdl_r[d] = a << 1;
                4'b0100: mdl_r[d] = a >> 1;
                4'b0101: mdl_r[d] = a & b;
                4'b0110: mdl_r[d] = a | b;
                4'b0111: mdl_r[d] = a ^ b;
                default: ;
            endcase
            if (op == 4'b1000 && a[0]) pc = (pc + int'($signed(b))) & (DEPTH - 1);
            else pc = (pc + 1) & (DEPTH - 1);
        end
    endtask

    task automatic drain();
        mon_en = 1'b1;
        wait (exp_q.size() == 0);
        @(negedge clk);
        #2;
        mon_en = 1'b0;
    endtask

    task automatic push_all(string tag);
        for (int i = 0; i < 8; i++) begin
            exp_t e;
            e.idx = i;
            e.val = mdl_r[i];
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < DEPTH; i++) prog[i] = enc(4'b1111, 0, 0, 0);
    endtask

    task automatic run_case(string tag);
        int steps;
        int edges;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            prog_we   = 1'b1;
            prog_addr = 5'(i);
            prog_word = prog[i][15:3];
        end
        @(negedge clk);
        prog_we = 1'b0;
        // reset state (R1)
        for (int i = 0; i < 8; i++) begin
            exp_t e;
            e.idx = i; e.val = 8'h00; e.tag = "R1";
            exp_q.push_back(e);
        end
        drain();
        chk(halted === 1'b0, "R1", "halted in reset", halted, 0);
        model_run(steps);
        @(negedge clk);
        rst_n = 1'b1;
        edges = 0;
        while (!halted && edges < 4000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        // R2 and R9: program loaded during reset runs with two cycles per instruction
        chk(edges == 2 * steps, "R9 R2", "cycles to halt", edges, 2 * steps);
        push_all(tag);
        drain();
        repeat (20) @(negedge clk);
        chk(halted === 1'b1, "R8", "halted held", halted, 1);
        push_all("R8 frozen");
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // Program A: arithmetic, logic and shifts on 0x18 and 0x14 (R3 R4 R5 R11)
        clear_prog();
        prog[0]  = enc(4'b0001, 1, 0, 0); // INV -> FF
        prog[1]  = enc(4'b0010, 2, 0, 1); // 0 - FF = 01
        prog[2]  = enc(4'b0011, 3, 2, 0); // 02
        prog[3]  = enc(4'b0011, 3, 3, 0); // 04
        prog[4]  = enc(4'b0011, 4, 3, 0); // 08
        prog[5]  = enc(4'b0011, 5, 4, 0); // 10
        prog[6]  = enc(4'b0110, 6, 5, 4); // 18
        prog[7]  = enc(4'b0110, 7, 5, 3); // 14
        prog[8]  = enc(4'b0111, 1, 6, 7); // 0C
        prog[9]  = enc(4'b0000, 2, 6, 7); // 2C
        prog[10] = enc(4'b0010, 3, 6, 7); // 04
        prog[11] = enc(4'b0011, 4, 6, 0); // 30
        prog[12] = enc(4'b0100, 5, 7, 0); // 0A
        prog[13] = enc(4'b0101, 0, 6, 7); // 10
        prog[14] = enc(4'b1111, 0, 0, 0);
        prog[15] = enc(4'b0001, 6, 0, 0); // after HALT
        run_case("R3 R4 R5 R11");
        chk(mdl_r[1] == 8'h0C && mdl_r[2] == 8'h2C && mdl_r[3] == 8'h04 && mdl_r[4] == 8'h30,
            "R3", "model sanity", mdl_r[2], 8'h2C);

        // Program B: loop closed by a backward branch (R6)
        clear_prog();
        prog[0]  = enc(4'b0001, 6, 0, 0); // FF
        prog[1]  = enc(4'b0010, 3, 0, 6); // 01
        prog[2]  = enc(4'b0000, 7, 6, 6); // FE = -2
        prog[3]  = enc(4'b0100, 1, 6, 0); // 7F
        prog[4]  = enc(4'b0100, 1, 1, 0); // 3F
        prog[5]  = enc(4'b0100, 1, 1, 0); // 1F
        prog[6]  = enc(4'b0100, 1, 1, 0); // 0F
        prog[7]  = enc(4'b0000, 2, 2, 3); // loop body
        prog[8]  = enc(4'b0100, 1, 1, 0);
        prog[9]  = enc(4'b1000, 0, 1, 7); // back to 7 while bit0
        prog[10] = enc(4'b0101, 4, 2, 6);
        prog[11] = enc(4'b0110, 5, 2, 3);
        run_case("R6 loop");
        chk(mdl_r[2] == 8'h04, "R6", "model loop count", mdl_r[2], 4);

        // Program C: branch wrapping below zero and sequential wrap past 31 (R7)
        clear_prog();
        prog[0]  = enc(4'b1000, 0, 1, 2); // first pass not taken, second to 8
        prog[1]  = enc(4'b0001, 6, 0, 0); // FF
        prog[2]  = enc(4'b0010, 3, 0, 6); // 01
        prog[3]  = enc(4'b0011, 2, 3, 0); // 02
        prog[4]  = enc(4'b0011, 2, 2, 0); // 04
        prog[5]  = enc(4'b0011, 2, 2, 0); // 08
        prog[6]  = enc(4'b0010, 7, 0, 2); // F8 = -8
        prog[7]  = enc(4'b1000, 0, 3, 7); // 7-8 -> 31
        prog[8]  = enc(4'b1111, 0, 0, 0);
        prog[9]  = enc(4'b0001, 5, 0, 0); // never reached
        for (int i = 10; i < 31; i++) prog[i] = enc(4'b0001, 4, 0, 0);
        prog[31] = enc(4'b0110, 1, 3, 3); // arm, then wrap to 0
        run_case("R7 wrap");
        chk(mdl_r[1] == 8'h01 && mdl_r[4] == 8'h00, "R7", "model wrap path", mdl_r[4], 0);

        // Program D: unused opcode, branch not taken with bit0 clear, HALT stops (R10 R6 R8)
        clear_prog();
        prog[0] = enc(4'b0001, 1, 0, 0); // FF
        prog[1] = enc(4'b1010, 1, 0, 0); // unused opcode
        prog[2] = enc(4'b1110, 2, 1, 1); // unused opcode
        prog[3] = enc(4'b0011, 3, 1, 0); // FE
        prog[4] = enc(4'b1000, 0, 3, 1); // bit0=0, not taken
        prog[5] = enc(4'b1111, 0, 0, 0);
        prog[6] = enc(4'b0001, 2, 0, 0); // after HALT
        run_case("R10 R6 R8");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule